// File: doc/BRIEF.md
# Flash Cache-Read Command Sequencer

This block is a host-side controller for a pipelined, multi-page cache read on a NAND-style flash that is reached through memory-mapped registers. A single start pulse carries a page count, a block and page address, a cache block and cache page address, a die select, a buffer select and an auto-interrupt flag. The block first checks the request. It then writes the address setup registers and issues one command per page over a simple register-bus master port. The strobes on that port are held until the flash side raises ready.

Each page reaches the host through a level `data_ready` and a one-cycle `consumed` pulse. The command for the next page waits until the host releases the current one. The first command is followed by a status poll, which waits for the ongoing and loaded bits to be set together. Every later command is followed by a wait on the interrupt pin and then a status read that can report an error. The last page is requested with a separate finish command. The sequence ends with a one-cycle `done` and a held `error` flag.

Top module: `cache_read_seq`

## Requirements
- R1: A start with a nonzero page count and an odd block address gives `done` and `error` high in the next cycle, and no bus strobe is raised.
- R2: A start with a page count of 0 gives `done` high and `error` low in the next cycle, and no bus strobe is raised.
- R3: Setup writes go in this order. First F101h with the buffer select in bit 15. Then F100h with the die select in bit 15 and the block address in the low bits. Then F102h with the cache block address in the low bits. Then F103h with the cache page in bits from 2 upward and the sector bits [1:0] set to 0. Then F107h with the page in the same layout. Last, F200h with data 0800h: start sector 1000b in bits [11:8] and sector count 00.
- R4: A strobe, write or read, stays high with a stable address and write data until ready is sampled high. Only one transfer happens per accepted strobe, and write and read are never high together.
- R5: Before every command, the block writes 0000h to F241h. This write is omitted when `auto_int` was high at start.
- R6: Commands go to F220h. The first n-1 commands are 000Eh and command n is 000Ch. With n = 1, the only command is 000Ch.
- R7: After the first command of a run with n of 2 or more, the block reads F240h repeatedly until bits 15 and 13 are both 1. Only then does it raise `data_ready`.
- R8: After every other command, the block waits for `int_in` to be high and then reads F240h. If bit 10 is set, the run ends with `error` and `done`, and no further page is handed over.
- R9: While `data_ready` is high there is no bus activity. After `consumed`, the next page's F107h write carries the previous page plus one, modulo the page width, and is followed by that page's command.
- R10: On success, `done` is high for exactly one cycle after the last `consumed`, with `error` low and `busy` low.
- R11: Page k, counting from 0, is presented with `ready_page` equal to the start page plus k. A run without error hands over exactly n pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while idle |
| page_count | input | CNT_W | Number of pages to read |
| blk_addr | input | BLK_W | Flash block address (must be even) |
| page_addr | input | PG_W | First page address |
| cache_blk | input | BLK_W | Cache block address |
| cache_page | input | PG_W | Cache page address |
| die_sel | input | 1 | Die select for the flash address |
| buf_sel | input | 1 | Buffer/die select written first |
| auto_int | input | 1 | Skip interrupt-clear writes |
| int_in | input | 1 | Flash interrupt pin |
| consumed | input | 1 | Host has drained the offered page |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 16 | Register bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 16 | Register bus read data |
| bus_ready | input | 1 | Transfer completes when high with a strobe |
| data_ready | output | 1 | A page is available to the host |
| ready_page | output | PG_W | Page address of the offered page |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Outcome of the last run |

## Verification
Two events can coincide. The flash side can complete a transfer in the very cycle its strobe first rises, and the host can answer `consumed` in the first cycle it sees `data_ready`. Some runs hold `bus_ready` high without a break and consume pages at once, so each completion and each release lands on the earliest possible edge. Other runs stall ready at random and delay consumption. Both kinds are judged against the same expected write transcript, the same page order and the same count of status reads, so a dropped or doubled transfer, or a command that skips ahead of the host, shows up as a mismatch.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int REG_AW = 16;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] REG_BLK  = 16'hF100;
  localparam logic [REG_AW-1:0] REG_BSEL = 16'hF101;
  localparam logic [REG_AW-1:0] REG_CBLK = 16'hF102;
  localparam logic [REG_AW-1:0] REG_CPG  = 16'hF103;
  localparam logic [REG_AW-1:0] REG_PG   = 16'hF107;
  localparam logic [REG_AW-1:0] REG_BUF  = 16'hF200;
  localparam logic [REG_AW-1:0] REG_CMD  = 16'hF220;
  localparam logic [REG_AW-1:0] REG_STAT = 16'hF240;
  localparam logic [REG_AW-1:0] REG_INT  = 16'hF241;

  localparam logic [REG_DW-1:0] CMD_CACHE = 16'h000E;
  localparam logic [REG_DW-1:0] CMD_FIN   = 16'h000C;

  localparam int ST_ONGO = 15;
  localparam int ST_LOAD = 13;
  localparam int ST_ERR  = 10;

  localparam logic [3:0] BUF_START_SECT = 4'b1000;
  localparam int BUF_START_LSB = 8;
  localparam int SECT_W = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_BSEL, S_BLK, S_CBLK, S_CPG, S_SPG, S_BUF,
    S_CLR, S_CMD, S_POLL, S_WINT, S_RDST, S_HAND, S_NPG
  } seq_state_t;

  typedef enum logic [3:0] {
    F_NONE, F_BSEL, F_BLK, F_CBLK, F_CPG, F_PG, F_BUF,
    F_ICLR, F_CMD_RD, F_CMD_FIN, F_STAT
  } fld_t;
endpackage

// File: rtl/crs_field_pack.sv
module crs_field_pack
  import crs_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int PG_W  = 6
) (
  input  fld_t               fld,
  input  logic               die,
  input  logic               bufsel,
  input  logic [BLK_W-1:0]   blk,
  input  logic [BLK_W-1:0]   cblk,
  input  logic [PG_W-1:0]    cpage,
  input  logic [PG_W-1:0]    page,
  output logic [REG_AW-1:0]  addr,
  output logic [REG_DW-1:0]  wdata,
  output logic               rd
);
  localparam int PG_LSB = SECT_W;
  localparam int PG_MSB = SECT_W + PG_W - 1;

  always_comb begin
    addr  = '0;
    wdata = '0;
    rd    = 1'b0;
    unique case (fld)
      F_BSEL: begin
        addr = REG_BSEL;
        wdata[REG_DW-1] = bufsel;
      end
      F_BLK: begin
        addr = REG_BLK;
        wdata[BLK_W-1:0] = blk;
        wdata[REG_DW-1]  = die;
      end
      F_CBLK: begin
        addr = REG_CBLK;
        wdata[BLK_W-1:0] = cblk;
      end
      F_CPG: begin
        addr = REG_CPG;
        wdata[PG_MSB:PG_LSB] = cpage;
      end
      F_PG: begin
        addr = REG_PG;
        wdata[PG_MSB:PG_LSB] = page;
      end
      F_BUF: begin
        addr = REG_BUF;
        wdata[BUF_START_LSB+3:BUF_START_LSB] = BUF_START_SECT;
      end
      F_ICLR:    addr = REG_INT;
      F_CMD_RD: begin
        addr  = REG_CMD;
        wdata = CMD_CACHE;
      end
      F_CMD_FIN: begin
        addr  = REG_CMD;
        wdata = CMD_FIN;
      end
      F_STAT: begin
        addr = REG_STAT;
        rd   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/crs_bus_master.sv
module crs_bus_master
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_rd,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [REG_DW-1:0] req_wdata,
  input  logic              bus_ready,
  input  logic [REG_DW-1:0] bus_rdata,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              op_done,
  output logic [REG_DW-1:0] op_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_done <= 1'b0;
      if (bus_we || bus_re) begin
        if (bus_ready) begin
          bus_we  <= 1'b0;
          bus_re  <= 1'b0;
          op_done <= 1'b1;
          if (bus_re) op_rdata <= bus_rdata;
        end
      end else if (req) begin
        bus_addr  <= req_addr;
        bus_wdata <= req_rd ? '0 : req_wdata;
        bus_we    <= !req_rd;
        bus_re    <= req_rd;
      end
    end
  end
endmodule

// File: rtl/crs_page_track.sv
module crs_page_track #(
  parameter int CNT_W = 8,
  parameter int PG_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic [PG_W-1:0]  page_in,
  input  logic             step,
  output logic [CNT_W-1:0] idx,
  output logic [PG_W-1:0]  cur_page,
  output logic             is_last
);
  logic [CNT_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx <= '0;
      idx      <= '0;
      cur_page <= '0;
    end else if (load) begin
      last_idx <= count_in - 1'b1;
      idx      <= '0;
      cur_page <= page_in;
    end else if (step) begin
      idx      <= idx + 1'b1;
      cur_page <= cur_page + 1'b1;
    end
  end

  assign is_last = (idx == last_idx);
endmodule

// File: rtl/cache_read_seq.sv
module cache_read_seq
  import crs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BLK_W = 12,
  parameter int PG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  page_count,
  input  logic [BLK_W-1:0]  blk_addr,
  input  logic [PG_W-1:0]   page_addr,
  input  logic [BLK_W-1:0]  cache_blk,
  input  logic [PG_W-1:0]   cache_page,
  input  logic              die_sel,
  input  logic              buf_sel,
  input  logic              auto_int,
  input  logic              int_in,
  input  logic              consumed,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [REG_DW-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              data_ready,
  output logic [PG_W-1:0]   ready_page,
  output logic              busy,
  output logic              done,
  output logic              error
);
  seq_state_t state;
  fld_t       fld;
  logic       op_sent, op_req;
  logic       bm_done;
  logic [REG_DW-1:0] bm_rdata;
  logic [REG_AW-1:0] op_addr;
  logic [REG_DW-1:0] op_wdata;
  logic       op_rd;

  logic [BLK_W-1:0] blk_q, cblk_q;
  logic [PG_W-1:0]  cpage_q;
  logic             die_q, buf_q, auto_q;

  logic             pt_load, pt_step, pt_last;
  logic [CNT_W-1:0] pt_idx;
  logic [PG_W-1:0]  pt_page;
  logic             accept;

  assign accept  = (state == S_IDLE) && start && (page_count != '0) && !blk_addr[0];
  assign pt_load = accept;
  assign pt_step = (state == S_HAND) && consumed && !pt_last;

  crs_page_track #(.CNT_W(CNT_W), .PG_W(PG_W)) u_track (
    .clk(clk), .rst(rst), .load(pt_load), .count_in(page_count),
    .page_in(page_addr), .step(pt_step), .idx(pt_idx),
    .cur_page(pt_page), .is_last(pt_last)
  );

  always_comb begin
    fld = F_NONE;
    unique case (state)
      S_BSEL:        fld = F_BSEL;
      S_BLK:         fld = F_BLK;
      S_CBLK:        fld = F_CBLK;
      S_CPG:         fld = F_CPG;
      S_SPG, S_NPG:  fld = F_PG;
      S_BUF:         fld = F_BUF;
      S_CLR:         fld = F_ICLR;
      S_CMD:         fld = pt_last ? F_CMD_FIN : F_CMD_RD;
      S_POLL, S_RDST: fld = F_STAT;
      default:       fld = F_NONE;
    endcase
  end

  assign op_req = (fld != F_NONE) && !op_sent;

  crs_field_pack #(.BLK_W(BLK_W), .PG_W(PG_W)) u_pack (
    .fld(fld), .die(die_q), .bufsel(buf_q), .blk(blk_q), .cblk(cblk_q),
    .cpage(cpage_q), .page(pt_page), .addr(op_addr), .wdata(op_wdata), .rd(op_rd)
  );

  crs_bus_master u_bus (
    .clk(clk), .rst(rst), .req(op_req), .req_rd(op_rd), .req_addr(op_addr),
    .req_wdata(op_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .op_done(bm_done), .op_rdata(bm_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_sent    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      data_ready <= 1'b0;
      ready_page <= '0;
      blk_q      <= '0;
      cblk_q     <= '0;
      cpage_q    <= '0;
      die_q      <= 1'b0;
      buf_q      <= 1'b0;
      auto_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bm_done)     op_sent <= 1'b0;
      else if (op_req) op_sent <= 1'b1;

      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (page_count == '0) begin
              done  <= 1'b1;
              error <= 1'b0;
            end else if (blk_addr[0]) begin
              done  <= 1'b1;
              error <= 1'b1;
            end else begin
              blk_q   <= blk_addr;
              cblk_q  <= cache_blk;
              cpage_q <= cache_page;
              die_q   <= die_sel;
              buf_q   <= buf_sel;
              auto_q  <= auto_int;
              error   <= 1'b0;
              busy    <= 1'b1;
              state   <= S_BSEL;
            end
          end
        end
        S_BSEL: if (bm_done) state <= S_BLK;
        S_BLK:  if (bm_done) state <= S_CBLK;
        S_CBLK: if (bm_done) state <= S_CPG;
        S_CPG:  if (bm_done) state <= S_SPG;
        S_SPG:  if (bm_done) state <= S_BUF;
        S_BUF:  if (bm_done) state <= auto_q ? S_CMD : S_CLR;
        S_NPG:  if (bm_done) state <= auto_q ? S_CMD : S_CLR;
        S_CLR:  if (bm_done) state <= S_CMD;
        S_CMD: begin
          if (bm_done)
            state <= ((pt_idx == '0) && !pt_last) ? S_POLL : S_WINT;
        end
        S_POLL: begin
          if (bm_done && bm_rdata[ST_ONGO] && bm_rdata[ST_LOAD]) begin
            state      <= S_HAND;
            data_ready <= 1'b1;
            ready_page <= pt_page;
          end
        end
        S_WINT: if (int_in) state <= S_RDST;
        S_RDST: begin
          if (bm_done) begin
            if (bm_rdata[ST_ERR]) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              error <= 1'b1;
            end else begin
              state      <= S_HAND;
              data_ready <= 1'b1;
              ready_page <= pt_page;
            end
          end
        end
        S_HAND: begin
          if (consumed) begin
            data_ready <= 1'b0;
            if (pt_last) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              state <= S_NPG;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int CNT_W = 8,
  parameter int BLK_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] page_count,
  input logic [BLK_W-1:0] blk_addr,
  input logic             bus_we,
  input logic             bus_re,
  input logic             bus_ready,
  input logic [15:0]      bus_addr,
  input logic [15:0]      bus_wdata,
  input logic             data_ready,
  input logic             consumed,
  input logic             busy,
  input logic             done,
  input logic             error
);
  p_odd_reject_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && page_count != '0 && blk_addr[0]) |=> (done && error));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(bus_we || bus_re));

  p_zero_count_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && page_count == '0) |=> (done && !error));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_ready) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));

  p_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_ready) |=> (bus_re && $stable(bus_addr)));

  p_bus_silent_r9: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> !(bus_we || bus_re));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (data_ready && consumed) |=> !data_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind cache_read_seq crs_checker #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_crs_checker (
  .clk(clk), .rst(rst), .start(start), .page_count(page_count),
  .blk_addr(blk_addr), .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .data_ready(data_ready),
  .consumed(consumed), .busy(busy), .done(done), .error(error)
);

// File: tb/cache_read_seq_bench.sv
module cache_read_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int BLK_W = 12;
  localparam int PG_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] page_count = '0;
  logic [BLK_W-1:0] blk_addr = '0, cache_blk = '0;
  logic [PG_W-1:0]  page_addr = '0, cache_page = '0;
  logic die_sel = 1'b0, buf_sel = 1'b0, auto_int = 1'b0;
  logic int_r;
  logic consumed = 1'b0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_we, bus_re;
  logic bus_ready = 1'b1;
  logic data_ready, busy, done, error;
  logic [PG_W-1:0] ready_page;

  int total = 0, bad = 0;
  bit finished = 0;

  int cfg_poll = 0, cfg_dly = 1, cfg_err_k = 0;
  bit cfg_err_en = 0, stall_mode = 0;

  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int log_n, cmd_cnt, int_cnt, poll_left, stat_rd, strobe_cnt;
  logic [15:0] exp_a [0:63];
  logic [15:0] exp_d [0:63];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_read_seq #(.CNT_W(CNT_W), .BLK_W(BLK_W), .PG_W(PG_W)) u_cache_read_seq (
    .clk(clk), .rst(rst), .start(start), .page_count(page_count),
    .blk_addr(blk_addr), .page_addr(page_addr), .cache_blk(cache_blk),
    .cache_page(cache_page), .die_sel(die_sel), .buf_sel(buf_sel),
    .auto_int(auto_int), .int_in(int_r), .consumed(consumed),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .data_ready(data_ready),
    .ready_page(ready_page), .busy(busy), .done(done), .error(error)
  );

  // flash-side register model
  always_comb begin
    bus_rdata = 16'h0000;
    if (bus_re && bus_addr == 16'hF240) begin
      bus_rdata = (poll_left == 0) ? 16'hA000 : 16'h8000;
      if (cfg_err_en && (cmd_cnt - 1 == cfg_err_k)) bus_rdata[10] = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      log_n <= 0; cmd_cnt <= 0; int_cnt <= 0; int_r <= 1'b1;
      poll_left <= cfg_poll; stat_rd <= 0; strobe_cnt <= 0;
    end else begin
      if (bus_we || bus_re) strobe_cnt <= strobe_cnt + 1;
      if (bus_re && bus_ready && bus_addr == 16'hF240) begin
        stat_rd <= stat_rd + 1;
        if (poll_left > 0) poll_left <= poll_left - 1;
      end
      if (bus_we && bus_ready) begin
        if (log_n < 64) begin
          log_a[log_n] <= bus_addr;
          log_d[log_n] <= bus_wdata;
        end
        log_n <= log_n + 1;
      end
      if (bus_we && bus_ready && bus_addr == 16'hF220) begin
        cmd_cnt <= cmd_cnt + 1;
        int_r   <= 1'b0;
        int_cnt <= cfg_dly;
      end else if (bus_we && bus_ready && bus_addr == 16'hF241) begin
        int_r <= 1'b0;
      end else if (int_cnt > 0) begin
        int_cnt <= int_cnt - 1;
        if (int_cnt == 1) int_r <= 1'b1;
      end
    end
  end

  always @(negedge clk) bus_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int len_through(input int k, input bit au);
    int s = 6;
    for (int i = 0; i <= k; i++) s += ((i > 0) ? 1 : 0) + (au ? 0 : 1) + 1;
    return s;
  endfunction

  task automatic build_exp(input int n, input int last, input logic [BLK_W-1:0] blk,
                           input logic [PG_W-1:0] pg, input logic [BLK_W-1:0] cb,
                           input logic [PG_W-1:0] cp, input bit die, input bit bs, input bit au);
    logic [PG_W-1:0] p;
    exp_n = 0;
    exp_a[0] = 16'hF101; exp_d[0] = {bs, 15'h0};
    exp_a[1] = 16'hF100; exp_d[1] = {die, 15'(blk)};
    exp_a[2] = 16'hF102; exp_d[2] = 16'(cb);
    exp_a[3] = 16'hF103; exp_d[3] = 16'(cp) << 2;
    exp_a[4] = 16'hF107; exp_d[4] = 16'(pg) << 2;
    exp_a[5] = 16'hF200; exp_d[5] = 16'h0800;
    exp_n = 6;
    for (int i = 0; i <= last; i++) begin
      if (i > 0) begin
        p = pg + PG_W'(i);
        exp_a[exp_n] = 16'hF107; exp_d[exp_n] = 16'(p) << 2; exp_n++;
      end
      if (!au) begin
        exp_a[exp_n] = 16'hF241; exp_d[exp_n] = 16'h0000; exp_n++;
      end
      exp_a[exp_n] = 16'hF220; exp_d[exp_n] = (i == n - 1) ? 16'h000C : 16'h000E; exp_n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_seq(input int n, input logic [BLK_W-1:0] blk, input logic [PG_W-1:0] pg,
                         input bit au, input bit stall, input int poll, input int dly,
                         input bit err_en, input int err_k, input int cons_max);
    logic [BLK_W-1:0] cb;
    logic [PG_W-1:0] cp, want_pg;
    bit die, bs, seen_done;
    int hand, last, w;
    string tag;
    cb = BLK_W'($urandom); cp = PG_W'($urandom);
    die = 1'($urandom); bs = 1'($urandom);
    cfg_poll = poll; cfg_dly = dly; cfg_err_en = err_en; cfg_err_k = err_k; stall_mode = stall;
    do_reset();
    page_count = CNT_W'(n); blk_addr = blk; page_addr = pg; cache_blk = cb; cache_page = cp;
    die_sel = die; buf_sel = bs; auto_int = au;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0 || blk[0]) begin
      tag = (n == 0) ? "R2" : "R1";
      check(done == 1'b1, tag, done, 1);
      check(error == ((n == 0) ? 1'b0 : 1'b1), tag, error, (n == 0) ? 0 : 1);
      repeat (4) @(negedge clk);
      check(strobe_cnt == 0, tag, strobe_cnt, 0);
      check(busy == 1'b0, tag, busy, 0);
      return;
    end
    hand = 0; seen_done = 0;
    while (!seen_done) begin
      if (data_ready) begin
        want_pg = pg + PG_W'(hand);
        check(ready_page == want_pg, "R11", ready_page, want_pg);
        check(log_n == len_through(hand, au), "R9", log_n, len_through(hand, au));
        if (hand == 0 && n >= 2) check(stat_rd == poll + 1, "R7", stat_rd, poll + 1);
        if (hand > 0 || n == 1) check(int_r == 1'b1, "R8", int_r, 1);
        w = (cons_max > 0) ? ($urandom % (cons_max + 1)) : 0;
        repeat (w) @(negedge clk);
        check(data_ready == 1'b1, "R9", data_ready, 1);
        consumed = 1'b1;
        @(negedge clk);
        consumed = 1'b0;
        hand++;
      end else if (done) begin
        seen_done = 1;
      end else begin
        @(negedge clk);
      end
    end
    last = err_en ? err_k : n - 1;
    check(error == err_en, err_en ? "R8" : "R10", error, err_en);
    check(hand == (err_en ? err_k : n), "R11", hand, err_en ? err_k : n);
    build_exp(n, last, blk, pg, cb, cp, die, bs, au);
    check(log_n == exp_n, stall ? "R4" : "R3", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (i < 6) tag = "R3";
      else if (exp_a[i] == 16'hF220) tag = "R6";
      else if (exp_a[i] == 16'hF241) tag = "R5";
      else tag = "R9";
      check(log_a[i] == exp_a[i], tag, log_a[i], exp_a[i]);
      check(log_d[i] == exp_d[i], tag, log_d[i], exp_d[i]);
    end
    @(negedge clk);
    check(done == 1'b0, "R10", done, 0);
    check(busy == 1'b0, "R10", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && data_ready == 1'b0, "R10", {done, busy, data_ready}, 0);
    check(bus_we == 1'b0 && bus_re == 1'b0, "R4", {bus_we, bus_re}, 0);
    rst = 1'b0;
    run_seq(0, 12'h010, 6'd3, 0, 0, 0, 1, 0, 0, 0);     // R2 zero count
    run_seq(3, 12'h011, 6'd3, 0, 0, 0, 1, 0, 0, 0);     // R1 odd block
    run_seq(1, 12'h020, 6'd5, 0, 0, 0, 2, 0, 0, 0);     // R6 single page finish only
    run_seq(3, 12'h040, 6'd9, 0, 0, 2, 1, 0, 0, 0);     // zero-wait, immediate consume
    run_seq(4, 12'h042, 6'd1, 1, 1, 3, 4, 0, 0, 3);     // R5 auto mode with stalls
    run_seq(4, 12'h100, 6'd7, 0, 1, 1, 3, 1, 2, 2);     // R8 error mid-run
    run_seq(1, 12'h200, 6'd0, 0, 0, 0, 2, 1, 0, 0);     // R8 error on single page
    run_seq(3, 12'h0FE, 6'd63, 0, 0, 0, 1, 0, 0, 1);    // R9 page wrap
    for (int r = 0; r < 12; r++) begin
      int n, ek;
      bit ee;
      n  = 1 + ($urandom % 6);
      ee = (($urandom % 4) == 0);
      ek = (n == 1) ? 0 : 1 + ($urandom % (n - 1));
      run_seq(n, BLK_W'($urandom) & ~BLK_W'(1), PG_W'($urandom), 1'($urandom),
              1'($urandom), $urandom % 4, 1 + ($urandom % 5), ee, ek, $urandom % 4);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule